// File: doc/BRIEF.md
# Synthesizer Divider and Phase Comparator

This block is the digital core of a frequency synthesizer. Two local-oscillator paths arrive as single-cycle edge strobes that have already been brought into the system clock domain. A two-bit selection code picks one of them to feed a programmable divide-by-N counter. The divided output is compared, edge against edge, with a reference strobe. A phase-frequency detector of this kind raises an "up" condition for a divider edge and a "down" condition for a reference edge, and clears both once both have arrived.

The charge-pump output is a drive-enable plus a level. It is driven high while the divided signal leads, meaning it runs faster than the reference. It is driven low while the reference leads. It is released when the edges match. It is also released whenever the run input is low, which covers stop, halt and backup, and during reset. A band indication goes with the chosen path, so the front end can pick its bandwidth. The divisor is written through a shadow register and only takes effect at the divider's next terminal count.

Top module: `synth_pll`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears: the pump is released (`pumpDrive`=0, `pumpLevel`=0), `bandHigh`=0, the counter is zero, and both the shadow and the active divisor become 1.
- R2: Selection code 2'b11 routes `fmTick` to the divider and 2'b10 routes `amTick`. While either is selected, the tick of the other path has no effect.
- R3: `bandHigh` is a registered flag. It reads 1 in the cycle after an edge that sampled `selCode`=2'b10, and 0 after any other code.
- R4: The divider produces one divided edge for every N selected ticks. With no reference edge pending, the pump drives high (`pumpDrive`=1, `pumpLevel`=1) starting two clock edges after the edge that sampled the Nth tick.
- R5: With no divided edge pending, a reference edge sampled at a clock edge makes the pump drive low (`pumpDrive`=1, `pumpLevel`=0) right after that edge.
- R6: Once both a divided edge and a reference edge have been registered, both conditions clear together and the pump is released. This also happens when both arrive on the same edge.
- R7: A value written with `nWrite` is held in a shadow register. It becomes the active divisor at the next terminal count. An active divisor of 0 behaves as 1.
- R8: While `pllRun` is low, both oscillator ticks and the reference are ignored, the counter is held at zero, and the pump is released after the next edge. The shadow divisor still accepts writes.
- R9: While the selection code is 2'b00 or 2'b01, the divider counter is held at zero and no divided edge is produced.
- R10: `pumpLevel` is 0 whenever `pumpDrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pllRun | input | 1 | 1 = synthesizer running; 0 = stop, halt or backup |
| selCode | input | 2 | Path selection: 11 FM, 10 AM, 0x none |
| fmTick | input | 1 | FM oscillator edge strobe |
| amTick | input | 1 | AM oscillator edge strobe |
| refTick | input | 1 | Reference edge strobe |
| nWrite | input | 1 | Write strobe for the shadow divisor |
| nData | input | 16 | Divisor value to write |
| bandHigh | output | 1 | 1 when the AM path (wide band) is selected |
| pumpDrive | output | 1 | Charge-pump drive enable; 0 = high impedance |
| pumpLevel | output | 1 | Charge-pump level while driven: 1 up, 0 down |

## Verification
Each result has its own latency. A reference strobe reaches the pump after one edge. A divided edge reaches the pump after two edges, because the terminal count is registered before the detector sees it. The band flag and the run and selection holds settle after one edge. The bench drives each stimulus one time unit after a rising edge. It then advances its behavioural model by exactly one edge per step and compares every output just after that edge, so every latency is checked at the cycle it is due.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int DIV_W = 16;

  typedef enum logic [1:0] {
    SEL_OFF0 = 2'b00,
    SEL_OFF1 = 2'b01,
    SEL_AM   = 2'b10,
    SEL_FM   = 2'b11
  } selCode_t;

  typedef struct packed {
    logic syncReset;  // clear every register
    logic holdZero;   // counter held at zero (stopped or no path)
    logic advance;    // one selected oscillator tick
    logic shadowWr;   // write the shadow divisor
    logic refStrobe;  // reference edge that may be used
    logic pfdClear;   // detector forced released
  } ctlStrobes_t;
endpackage

// File: rtl/synth_ctl.sv
module synth_ctl
  import synth_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pllRun,
  input  logic [1:0]  selCode,
  input  logic        fmTick,
  input  logic        amTick,
  input  logic        refTick,
  input  logic        nWrite,
  output ctlStrobes_t strobes,
  output logic        bandHigh
);
  selCode_t selNow;
  logic     pathOn;
  logic     pathTick;

  assign selNow = selCode_t'(selCode);

  always_comb begin
    pathOn   = 1'b0;
    pathTick = 1'b0;
    unique case (selNow)
      SEL_FM: begin pathOn = 1'b1; pathTick = fmTick; end
      SEL_AM: begin pathOn = 1'b1; pathTick = amTick; end
      default: begin pathOn = 1'b0; pathTick = 1'b0; end
    endcase
  end

  always_comb begin
    strobes.syncReset = rst;
    strobes.holdZero  = rst | ~pllRun | ~pathOn;
    strobes.advance   = ~rst & pllRun & pathOn & pathTick;
    strobes.shadowWr  = ~rst & nWrite;
    strobes.refStrobe = ~rst & pllRun & refTick;
    strobes.pfdClear  = rst | ~pllRun;
  end

  always_ff @(posedge clk) begin
    if (rst) bandHigh <= 1'b0;
    else     bandHigh <= (selNow == SEL_AM);
  end
endmodule

// File: rtl/synth_div.sv
module synth_div
  import synth_pkg::*;
#(
  parameter int NW      = DIV_W,
  parameter int RESET_N = 1
) (
  input  logic            clk,
  input  ctlStrobes_t     strobes,
  input  logic [NW-1:0]   nData,
  output logic            divPulse,
  output logic [NW-1:0]   divCount
);
  localparam logic [NW-1:0] N_ONE   = NW'(1);
  localparam logic [NW-1:0] N_RESET = NW'(RESET_N);

  logic [NW-1:0] nShadow;
  logic [NW-1:0] nActive;
  logic [NW-1:0] nLast;
  logic          atTerminal;

  always_comb begin
    nLast      = (nActive == '0) ? '0 : (nActive - N_ONE);
    atTerminal = strobes.advance & (divCount >= nLast);
  end

  always_ff @(posedge clk) begin
    if (strobes.syncReset) begin
      nShadow <= N_RESET;
    end else if (strobes.shadowWr) begin
      nShadow <= nData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.syncReset) begin
      nActive  <= N_RESET;
      divCount <= '0;
      divPulse <= 1'b0;
    end else if (strobes.holdZero) begin
      divCount <= '0;
      divPulse <= 1'b0;
    end else if (atTerminal) begin
      nActive  <= nShadow;
      divCount <= '0;
      divPulse <= 1'b1;
    end else begin
      if (strobes.advance) divCount <= divCount + N_ONE;
      divPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd
  import synth_pkg::*;
(
  input  logic        clk,
  input  ctlStrobes_t strobes,
  input  logic        divPulse,
  output logic        upFlag,
  output logic        dnFlag
);
  logic upNext;
  logic dnNext;

  always_comb begin
    upNext = upFlag | divPulse;
    dnNext = dnFlag | strobes.refStrobe;
    if (upNext & dnNext) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.pfdClear) begin
      upFlag <= 1'b0;
      dnFlag <= 1'b0;
    end else begin
      upFlag <= upNext;
      dnFlag <= dnNext;
    end
  end
endmodule

// File: rtl/synth_pll.sv
module synth_pll
  import synth_pkg::*;
#(
  parameter int NW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pllRun,
  input  logic [1:0]    selCode,
  input  logic          fmTick,
  input  logic          amTick,
  input  logic          refTick,
  input  logic          nWrite,
  input  logic [NW-1:0] nData,
  output logic          bandHigh,
  output logic          pumpDrive,
  output logic          pumpLevel
);
  ctlStrobes_t   strobes;
  logic          divPulse;
  logic [NW-1:0] divCount;
  logic          upFlag;
  logic          dnFlag;

  synth_ctl u_ctl (
    .clk(clk), .rst(rst), .pllRun(pllRun), .selCode(selCode),
    .fmTick(fmTick), .amTick(amTick), .refTick(refTick),
    .nWrite(nWrite), .strobes(strobes), .bandHigh(bandHigh)
  );

  synth_div #(.NW(NW), .RESET_N(1)) u_div (
    .clk(clk), .strobes(strobes), .nData(nData),
    .divPulse(divPulse), .divCount(divCount)
  );

  synth_pfd u_pfd (
    .clk(clk), .strobes(strobes), .divPulse(divPulse),
    .upFlag(upFlag), .dnFlag(dnFlag)
  );

  assign pumpDrive = upFlag ^ dnFlag;
  assign pumpLevel = upFlag & ~dnFlag;
endmodule

// File: rtl/synth_pll_chk.sv
module synth_pll_chk #(
  parameter int NW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          pllRun,
  input logic [1:0]    selCode,
  input logic          refTick,
  input logic          bandHigh,
  input logic          pumpDrive,
  input logic          pumpLevel,
  input logic          divPulse,
  input logic [NW-1:0] divCount
);
  p_band_am_r3: assert property (@(posedge clk) disable iff (rst)
    (selCode == 2'b10) |=> bandHigh);
  p_band_other_r3: assert property (@(posedge clk) disable iff (rst)
    (selCode != 2'b10) |=> !bandHigh);
  p_up_from_divider_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(pumpDrive) && pumpLevel) |-> $past(divPulse));
  p_down_from_ref_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(pumpDrive) && !pumpLevel) |-> $past(refTick && pllRun));
  p_stop_release_r8: assert property (@(posedge clk) disable iff (rst)
    !pllRun |=> (!pumpDrive && divCount == '0 && !divPulse));
  p_no_path_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !selCode[1] |=> (divCount == '0 && !divPulse));
  p_level_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !pumpDrive |-> !pumpLevel);
  p_pulse_restart_r4: assert property (@(posedge clk) disable iff (rst)
    divPulse |-> divCount == '0);
endmodule

bind synth_pll synth_pll_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst(rst), .pllRun(pllRun), .selCode(selCode),
  .refTick(refTick), .bandHigh(bandHigh), .pumpDrive(pumpDrive),
  .pumpLevel(pumpLevel), .divPulse(divPulse), .divCount(divCount)
);

// File: tb/sim_synth_pll.sv
module sim_synth_pll;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pllRun = 1'b0;
  logic [1:0]  selCode = 2'b00;
  logic        fmTick = 1'b0;
  logic        amTick = 1'b0;
  logic        refTick = 1'b0;
  logic        nWrite = 1'b0;
  logic [15:0] nData = 16'd0;
  logic        bandHigh;
  logic        pumpDrive;
  logic        pumpLevel;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  // behavioural model state
  int mCnt, mNAct, mNSh;
  bit mDiv, mUp, mDn, mBand;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_pll u0 (
    .clk(clk), .rst(rst), .pllRun(pllRun), .selCode(selCode),
    .fmTick(fmTick), .amTick(amTick), .refTick(refTick),
    .nWrite(nWrite), .nData(nData), .bandHigh(bandHigh),
    .pumpDrive(pumpDrive), .pumpLevel(pumpLevel)
  );

  task automatic modelEdge();
    bit tick, active, newDiv, u, d;
    int eff, oldSh;
    if (rst) begin
      mCnt = 0; mNAct = 1; mNSh = 1; mDiv = 0; mUp = 0; mDn = 0; mBand = 0;
      return;
    end
    mBand = (selCode == 2'b10);
    active = pllRun && selCode[1];
    tick = (selCode == 2'b11) ? fmTick : (selCode == 2'b10) ? amTick : 1'b0;
    oldSh = mNSh;
    if (nWrite) mNSh = nData;
    newDiv = 0;
    if (!active) mCnt = 0;
    else if (tick) begin
      eff = (mNAct == 0) ? 1 : mNAct;
      if (mCnt + 1 >= eff) begin
        mCnt = 0; mNAct = oldSh; newDiv = 1;
      end else mCnt = mCnt + 1;
    end
    if (!pllRun) begin
      mUp = 0; mDn = 0;
    end else begin
      u = mUp | mDiv;
      d = mDn | refTick;
      if (u && d) begin u = 0; d = 0; end
      mUp = u; mDn = d;
    end
    mDiv = newDiv;
  endtask

  task automatic compare();
    bit eDrive, eLevel;
    eDrive = mUp ^ mDn;
    eLevel = mUp & ~mDn;
    checks++;
    if (pumpDrive !== eDrive || pumpLevel !== eLevel || bandHigh !== mBand) begin
      errors++;
      $display("FAIL %s at %0t: drive/level/band actual %b%b%b expected %b%b%b",
               curReq, $time, pumpDrive, pumpLevel, bandHigh, eDrive, eLevel, mBand);
    end
  endtask

  task automatic step(input bit r, input bit run, input logic [1:0] s,
                      input bit f, input bit a, input bit rf,
                      input bit w = 0, input int nd = 0);
    rst = r; pllRun = run; selCode = s; fmTick = f; amTick = a;
    refTick = rf; nWrite = w; nData = 16'(nd);
    @(posedge clk);
    #1;
    modelEdge();
    compare();
  endtask

  task automatic idle(input logic [1:0] s, input int n);
    for (int i = 0; i < n; i++) step(0, 1, s, 0, 0, 0);
  endtask

  initial begin
    // R1: reset state
    curReq = "R1";
    step(1, 0, 2'b11, 1, 1, 1);
    step(1, 1, 2'b10, 1, 1, 1);
    step(1, 1, 2'b11, 0, 0, 0);
    idle(2'b11, 2);

    // R7: write N=3; it loads at the next terminal (active N is 1)
    curReq = "R7";
    step(0, 1, 2'b11, 0, 0, 0, 1, 3);
    step(0, 1, 2'b11, 1, 0, 0);   // terminal with N=1, loads 3
    idle(2'b11, 2);
    curReq = "R6";
    step(0, 1, 2'b11, 0, 0, 1);   // reference cancels the pending up
    idle(2'b11, 2);

    // R2/R4: FM path, three ticks then drive high; AM ticks ignored
    curReq = "R2/R4/R10";
    step(0, 1, 2'b11, 1, 1, 0);
    step(0, 1, 2'b11, 0, 1, 0);
    step(0, 1, 2'b11, 1, 0, 0);
    step(0, 1, 2'b11, 0, 1, 0);
    step(0, 1, 2'b11, 1, 0, 0);   // third tick
    idle(2'b11, 3);
    curReq = "R6";
    step(0, 1, 2'b11, 0, 0, 1);
    idle(2'b11, 2);

    // R5: reference alone drives low
    curReq = "R5/R10";
    step(0, 1, 2'b11, 0, 0, 1);
    idle(2'b11, 2);
    step(0, 1, 2'b11, 0, 0, 1);
    idle(2'b11, 2);
    curReq = "R6";
    for (int i = 0; i < 3; i++) step(0, 1, 2'b11, 1, 0, 0);
    idle(2'b11, 3);

    // R6: divided edge and reference on the same edge
    for (int i = 0; i < 2; i++) step(0, 1, 2'b11, 1, 0, 0);
    step(0, 1, 2'b11, 1, 0, 0);
    step(0, 1, 2'b11, 0, 0, 1);
    idle(2'b11, 3);

    // R2/R3: AM path, FM ticks ignored, band flag set
    curReq = "R2/R3";
    for (int i = 0; i < 4; i++) step(0, 1, 2'b10, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 2'b10, 0, 1, 0);
    idle(2'b10, 3);
    step(0, 1, 2'b10, 0, 0, 1);
    idle(2'b11, 2);

    // R7: N change mid-count and N=0
    curReq = "R7";
    step(0, 1, 2'b11, 1, 0, 0);
    step(0, 1, 2'b11, 0, 0, 0, 1, 5);
    for (int i = 0; i < 12; i++) step(0, 1, 2'b11, 1, 0, i % 2 == 0);
    step(0, 1, 2'b11, 0, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) step(0, 1, 2'b11, 1, 0, i % 3 == 0);
    idle(2'b11, 3);

    // R8: stopped, inputs ignored, shadow still writable
    curReq = "R8";
    step(0, 1, 2'b11, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 2'b11, 1, 1, 1);
    step(0, 0, 2'b11, 0, 0, 0, 1, 2);
    for (int i = 0; i < 6; i++) step(0, 1, 2'b11, 1, 0, 0);
    step(0, 0, 2'b11, 0, 0, 0);
    idle(2'b11, 2);

    // R9: no path selected
    curReq = "R9";
    step(0, 1, 2'b11, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 2'b00, 1, 1, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 2'b01, 1, 1, 0);
    for (int i = 0; i < 2; i++) step(0, 1, 2'b11, 1, 0, 0);
    idle(2'b11, 3);

    // mixed stimulus
    curReq = "R2/R4/R5/R6/R7/R8";
    for (int i = 0; i < 600; i++) begin
      int rv;
      rv = $urandom;
      step(0, (rv % 23) != 0, (rv % 17 == 0) ? 2'b01 : ((rv % 11 == 0) ? 2'b10 : 2'b11),
           rv[8], rv[9], rv[10] & rv[11], rv[12] & rv[13] & rv[14], (rv >> 16) % 6);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule